// File: doc/BRIEF.md
# Register Result Status Table

This block keeps, for every architectural register of an out-of-order core, either a committed value or the tag of the reservation station that will produce its next value. There are two banks. One holds 16 floating-point registers, which are addressed by even register numbers 0 to 30. The other holds 32 integer registers, which supply base addresses for loads and stores.

The issue stage uses the block in three ways:
- It looks up two source operands per cycle. Each lookup returns either a ready value or a pending tag.
- It marks the destination register of the instruction being issued with the tag of the station it was given. The tag is recorded at the next clock edge.
- The block watches the common result bus. Any register whose pending tag matches a broadcast takes the value and becomes ready.

A lookup made while a matching broadcast is on the bus returns the broadcast value directly. This means an operand never misses a result that is being delivered in the same cycle.

Top module: `regstat_table`

## Requirements
- R1: After reset, every floating-point register reads value 1 and not pending. Every integer register reads value 0 and not pending, except integer register 1, which reads 16.
- R2: A lookup of a ready register returns pend=0, tag=0 and the stored value. A lookup of a pending register returns pend=1, value=0 and the producer tag.
- R3: Floating-point lookups and writes use register number bit 0 as don't-care, so the table entry is the number shifted right by one. Integer lookups and writes use the full 5-bit number.
- R4: A destination write (`wr_en`=1) makes the selected register pending on `wr_tag` from the next cycle. It replaces any earlier pending tag.
- R5: A broadcast (`cdb_valid`=1) stores `cdb_value` in every register, in either bank, that is pending on `cdb_tag`, and clears their pending state from the next cycle.
- R6: A broadcast whose tag matches no pending register, and any bus contents while `cdb_valid`=0, leave every register unchanged.
- R7: When a destination write and a matching broadcast hit the same register in the same cycle, the register ends pending on the newly written tag.
- R8: A lookup of a register pending on the tag currently broadcast with `cdb_valid`=1 returns pend=0 and `cdb_value` in that same cycle.
- R9: A lookup and a destination write to the same register in the same cycle return the state from before the write.
- R10: `wr_fp`/`rdN_fp` select the bank (1 = floating point, 0 = integer). A write to one bank never alters the other, and the two lookup ports act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_fp | input | 1 | Lookup 0 bank select, 1 = floating point |
| rd0_num | input | 5 | Lookup 0 register number |
| rd0_pend | output | 1 | Lookup 0 operand still pending |
| rd0_tag | output | 4 | Lookup 0 producer tag (0 when ready) |
| rd0_val | output | 32 | Lookup 0 value (0 when pending) |
| rd1_fp | input | 1 | Lookup 1 bank select |
| rd1_num | input | 5 | Lookup 1 register number |
| rd1_pend | output | 1 | Lookup 1 operand still pending |
| rd1_tag | output | 4 | Lookup 1 producer tag |
| rd1_val | output | 32 | Lookup 1 value |
| wr_en | input | 1 | Destination tag write enable |
| wr_fp | input | 1 | Destination bank select |
| wr_num | input | 5 | Destination register number |
| wr_tag | input | 4 | Tag of the allocated station |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | 4 | Tag of the broadcasting station |
| cdb_value | input | 32 | Broadcast result value |

## Verification
The hardest case to reach is a single register that, in one cycle, is pending on the broadcast tag, is the target of a fresh destination write, and is being looked up. That register's final state depends only on the priority of the write over the bus. The stimulus builds up to it in steps:
- It first renames every floating-point register to its own tag, with one tag shared across the two banks.
- It overwrites one pending tag.
- It sweeps a broadcast over all sixteen tags while looking up the matching register, so that the bypass is seen.
- Finally it stages the write-versus-broadcast collision on a register it has just renamed.

// File: rtl/regstat_pkg.sv
package regstat_pkg;
  parameter int unsigned RS_TAG_W  = 4;
  parameter int unsigned RS_DATA_W = 32;

  typedef struct packed {
    logic                 pend;
    logic [RS_TAG_W-1:0]  tag;
    logic [RS_DATA_W-1:0] val;
  } rs_entry_t;
endpackage

// File: rtl/regstat_entry.sv
module regstat_entry
  import regstat_pkg::*;
#(
  parameter logic [RS_DATA_W-1:0] RST_VAL = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [RS_TAG_W-1:0]  wr_tag,
  input  logic                 cdb_valid,
  input  logic [RS_TAG_W-1:0]  cdb_tag,
  input  logic [RS_DATA_W-1:0] cdb_value,
  output rs_entry_t            q
);
  rs_entry_t nxt;
  logic      hit;
  logic      upd;

  always_comb begin
    hit = cdb_valid && q.pend && (q.tag == cdb_tag);
    upd = wr_en || hit;
    nxt = q;
    if (hit) begin
      nxt.pend = 1'b0;
      nxt.val  = cdb_value;
    end
    if (wr_en) begin
      nxt.pend = 1'b1;
      nxt.tag  = wr_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.pend <= 1'b0;
      q.tag  <= '0;
      q.val  <= RST_VAL;
    end else if (upd) begin
      q <= nxt;
    end
  end

  AST_WR_SETS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (q.pend && q.tag == $past(wr_tag))); // R4
  AST_BCAST_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (cdb_valid && q.pend && q.tag == cdb_tag && !wr_en) |=> (!q.pend && q.val == $past(cdb_value))); // R5
  AST_NEW_TAG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && cdb_valid && q.pend && q.tag == cdb_tag) |=> (q.pend && q.tag == $past(wr_tag))); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !(cdb_valid && q.pend && q.tag == cdb_tag)) |=> $stable(q)); // R6
endmodule

// File: rtl/regstat_bank.sv
module regstat_bank
  import regstat_pkg::*;
#(
  parameter int unsigned          NUM_REGS = 16,
  parameter int unsigned          NUM_RD   = 2,
  parameter logic [RS_DATA_W-1:0] INIT_VAL = '0,
  parameter int                   SEED_IDX = -1,
  parameter logic [RS_DATA_W-1:0] SEED_VAL = '0,
  localparam int unsigned         IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [RS_TAG_W-1:0]  wr_tag,
  input  logic                 cdb_valid,
  input  logic [RS_TAG_W-1:0]  cdb_tag,
  input  logic [RS_DATA_W-1:0] cdb_value,
  input  logic [IDX_W-1:0]     rd_idx [NUM_RD],
  output rs_entry_t            rd_res [NUM_RD]
);
  rs_entry_t ent [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_ent
    localparam logic [RS_DATA_W-1:0] EVAL = (i == SEED_IDX) ? SEED_VAL : INIT_VAL;
    logic sel_wr;
    assign sel_wr = wr_en && (wr_idx == IDX_W'(i));
    regstat_entry #(.RST_VAL(EVAL)) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (sel_wr),
      .wr_tag    (wr_tag),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_value (cdb_value),
      .q         (ent[i])
    );
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
    rs_entry_t sel;
    logic      byp;
    always_comb begin
      sel = ent[rd_idx[p]];
      byp = cdb_valid && sel.pend && (sel.tag == cdb_tag);
      rd_res[p].pend = sel.pend && !byp;
      rd_res[p].tag  = rd_res[p].pend ? sel.tag : '0;
      if (rd_res[p].pend)
        rd_res[p].val = '0;
      else if (byp)
        rd_res[p].val = cdb_value;
      else
        rd_res[p].val = sel.val;
    end

    AST_BYPASS_NOT_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (cdb_valid && rd_res[p].pend) |-> (rd_res[p].tag != cdb_tag)); // R8
  end
endmodule

// File: rtl/regstat_table.sv
module regstat_table
  import regstat_pkg::*;
#(
  parameter int unsigned NUM_FP   = 16,
  parameter int unsigned NUM_INT  = 32,
  parameter int unsigned FP_INIT  = 1,
  parameter int unsigned INT_INIT = 0,
  parameter int          INT_SEED = 1,
  parameter int unsigned SEED_VAL = 16,
  parameter int unsigned NUM_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd0_fp,
  input  logic [NUM_W-1:0]     rd0_num,
  output logic                 rd0_pend,
  output logic [RS_TAG_W-1:0]  rd0_tag,
  output logic [RS_DATA_W-1:0] rd0_val,
  input  logic                 rd1_fp,
  input  logic [NUM_W-1:0]     rd1_num,
  output logic                 rd1_pend,
  output logic [RS_TAG_W-1:0]  rd1_tag,
  output logic [RS_DATA_W-1:0] rd1_val,
  input  logic                 wr_en,
  input  logic                 wr_fp,
  input  logic [NUM_W-1:0]     wr_num,
  input  logic [RS_TAG_W-1:0]  wr_tag,
  input  logic                 cdb_valid,
  input  logic [RS_TAG_W-1:0]  cdb_tag,
  input  logic [RS_DATA_W-1:0] cdb_value
);
  localparam int unsigned NRD   = 2;
  localparam int unsigned FP_W  = $clog2(NUM_FP);
  localparam int unsigned INT_W = $clog2(NUM_INT);

  logic             rd_fp  [NRD];
  logic [NUM_W-1:0] rd_num [NRD];
  logic [FP_W-1:0]  fp_idx [NRD];
  logic [INT_W-1:0] int_idx[NRD];
  rs_entry_t        fp_res [NRD];
  rs_entry_t        int_res[NRD];
  rs_entry_t        mux_res[NRD];

  assign rd_fp[0]  = rd0_fp;
  assign rd_fp[1]  = rd1_fp;
  assign rd_num[0] = rd0_num;
  assign rd_num[1] = rd1_num;

  for (genvar p = 0; p < NRD; p++) begin : g_port
    assign fp_idx[p]  = rd_num[p][FP_W:1];
    assign int_idx[p] = rd_num[p][INT_W-1:0];
    assign mux_res[p] = rd_fp[p] ? fp_res[p] : int_res[p];
  end

  assign rd0_pend = mux_res[0].pend;
  assign rd0_tag  = mux_res[0].tag;
  assign rd0_val  = mux_res[0].val;
  assign rd1_pend = mux_res[1].pend;
  assign rd1_tag  = mux_res[1].tag;
  assign rd1_val  = mux_res[1].val;

  logic fp_we;
  logic int_we;
  assign fp_we  = wr_en && wr_fp;
  assign int_we = wr_en && !wr_fp;

  regstat_bank #(
    .NUM_REGS (NUM_FP),
    .NUM_RD   (NRD),
    .INIT_VAL (RS_DATA_W'(FP_INIT)),
    .SEED_IDX (-1),
    .SEED_VAL ('0)
  ) u_fp_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (fp_we),
    .wr_idx    (wr_num[FP_W:1]),
    .wr_tag    (wr_tag),
    .cdb_valid (cdb_valid),
    .cdb_tag   (cdb_tag),
    .cdb_value (cdb_value),
    .rd_idx    (fp_idx),
    .rd_res    (fp_res)
  );

  regstat_bank #(
    .NUM_REGS (NUM_INT),
    .NUM_RD   (NRD),
    .INIT_VAL (RS_DATA_W'(INT_INIT)),
    .SEED_IDX (INT_SEED),
    .SEED_VAL (RS_DATA_W'(SEED_VAL))
  ) u_int_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (int_we),
    .wr_idx    (wr_num[INT_W-1:0]),
    .wr_tag    (wr_tag),
    .cdb_valid (cdb_valid),
    .cdb_tag   (cdb_tag),
    .cdb_value (cdb_value),
    .rd_idx    (int_idx),
    .rd_res    (int_res)
  );

  AST_PEND_HAS_NO_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    rd0_pend |-> (rd0_val == '0)); // R2
endmodule

// File: tb/tb_regstat_table.sv
module tb_regstat_table;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rd0_fp, rd1_fp, wr_en, wr_fp, cdb_valid;
  logic [4:0]  rd0_num, rd1_num, wr_num;
  logic [3:0]  wr_tag, cdb_tag, rd0_tag, rd1_tag;
  logic [31:0] cdb_value, rd0_val, rd1_val;
  logic        rd0_pend, rd1_pend;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic        mf_pend [16];
  logic [3:0]  mf_tag  [16];
  logic [31:0] mf_val  [16];
  logic        mi_pend [32];
  logic [3:0]  mi_tag  [32];
  logic [31:0] mi_val  [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  regstat_table dut (
    .clk(clk), .rst_n(rst_n),
    .rd0_fp(rd0_fp), .rd0_num(rd0_num), .rd0_pend(rd0_pend), .rd0_tag(rd0_tag), .rd0_val(rd0_val),
    .rd1_fp(rd1_fp), .rd1_num(rd1_num), .rd1_pend(rd1_pend), .rd1_tag(rd1_tag), .rd1_val(rd1_val),
    .wr_en(wr_en), .wr_fp(wr_fp), .wr_num(wr_num), .wr_tag(wr_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value)
  );

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic step();
    for (int j = 0; j < 16; j++) begin
      if (mf_pend[j] && cdb_valid && mf_tag[j] == cdb_tag) begin
        mf_pend[j] = 0; mf_val[j] = cdb_value;
      end
      if (wr_en && wr_fp && int'(wr_num >> 1) == j) begin
        mf_pend[j] = 1; mf_tag[j] = wr_tag;
      end
    end
    for (int j = 0; j < 32; j++) begin
      if (mi_pend[j] && cdb_valid && mi_tag[j] == cdb_tag) begin
        mi_pend[j] = 0; mi_val[j] = cdb_value;
      end
      if (wr_en && !wr_fp && int'(wr_num) == j) begin
        mi_pend[j] = 1; mi_tag[j] = wr_tag;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input int port, input string req);
    logic fp, ap, mp, bp, ep;
    logic [4:0] num;
    logic [3:0] at, mt, et;
    logic [31:0] av, mv, ev;
    int idx;
    if (port == 0) begin fp = rd0_fp; num = rd0_num; ap = rd0_pend; at = rd0_tag; av = rd0_val; end
    else           begin fp = rd1_fp; num = rd1_num; ap = rd1_pend; at = rd1_tag; av = rd1_val; end
    if (fp) begin idx = int'(num >> 1); mp = mf_pend[idx]; mt = mf_tag[idx]; mv = mf_val[idx]; end
    else    begin idx = int'(num);      mp = mi_pend[idx]; mt = mi_tag[idx]; mv = mi_val[idx]; end
    bp = cdb_valid && mp && mt == cdb_tag;
    ep = mp && !bp;
    et = ep ? mt : 4'd0;
    ev = ep ? 32'd0 : (bp ? cdb_value : mv);
    n_chk++;
    if (ap !== ep || at !== et || av !== ev) begin
      n_fail++;
      $display("FAIL %s port%0d fp=%0d num=%0d: got pend=%0d tag=%0d val=%0d, expected pend=%0d tag=%0d val=%0d",
               req, port, fp, num, ap, at, av, ep, et, ev);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_fp = 0; wr_num = 0; wr_tag = 0;
    cdb_valid = 0; cdb_tag = 0; cdb_value = 0;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < 32; i++) begin
      rd0_fp = 1; rd0_num = 5'(i);
      rd1_fp = 0; rd1_num = 5'(i);
      #1;
      chk(0, req);
      chk(1, req);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0;
    idle();
    rd0_fp = 1; rd0_num = 0; rd1_fp = 0; rd1_num = 0;
    for (int j = 0; j < 16; j++) begin mf_pend[j] = 0; mf_tag[j] = 0; mf_val[j] = 1; end
    for (int j = 0; j < 32; j++) begin mi_pend[j] = 0; mi_tag[j] = 0; mi_val[j] = (j == 1) ? 32'd16 : 32'd0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1 reset state, R2 ready read form
    sweep("R1");

    // R4 rename each fp register to its own tag
    for (int k = 0; k < 16; k++) begin
      wr_en = 1; wr_fp = 1; wr_num = 5'(2 * k); wr_tag = 4'(k);
      step();
    end
    // R10 integer write with a tag also used in fp bank
    wr_en = 1; wr_fp = 0; wr_num = 5; wr_tag = 3;
    step();
    // R4 overwrite fp4's pending tag
    wr_en = 1; wr_fp = 1; wr_num = 4; wr_tag = 9;
    step();
    idle();
    // R3 odd numbers alias, R2 pending form, R10 bank isolation
    sweep("R3");

    // R6 bus contents ignored while not valid
    cdb_valid = 0; cdb_tag = 0; cdb_value = 55;
    step();
    idle();
    rd0_fp = 1; rd0_num = 0; #1; chk(0, "R6");

    // R8 bypass during broadcast, R5 fill afterwards
    for (int k = 0; k < 16; k++) begin
      cdb_valid = 1; cdb_tag = 4'(k); cdb_value = 32'(100 + k);
      rd0_fp = 1; rd0_num = 5'(2 * k);
      rd1_fp = 1; rd1_num = 4;
      #1;
      chk(0, "R8");
      chk(1, "R8");
      step();
    end
    idle();
    sweep("R5");

    // R6 broadcast to a ready register
    cdb_valid = 1; cdb_tag = 0; cdb_value = 7;
    rd0_fp = 1; rd0_num = 0; #1; chk(0, "R6");
    step();
    idle();
    #1; chk(0, "R6");

    // R7 collision of write and matching broadcast
    wr_en = 1; wr_fp = 1; wr_num = 10; wr_tag = 5;
    step();
    wr_en = 1; wr_fp = 1; wr_num = 10; wr_tag = 6;
    cdb_valid = 1; cdb_tag = 5; cdb_value = 77;
    rd0_fp = 1; rd0_num = 10; #1; chk(0, "R8");
    step();
    idle();
    #1; chk(0, "R7");
    cdb_valid = 1; cdb_tag = 6; cdb_value = 88;
    step();
    idle();
    #1; chk(0, "R7");

    // R9 lookup in the same cycle as a write to the same register
    wr_en = 1; wr_fp = 1; wr_num = 12; wr_tag = 1;
    rd0_fp = 1; rd0_num = 12; rd1_fp = 1; rd1_num = 13;
    #1; chk(0, "R9"); chk(1, "R9");
    step();
    idle();
    #1; chk(0, "R9");

    // R10 integer write leaves the fp register of the same number alone
    wr_en = 1; wr_fp = 0; wr_num = 7; wr_tag = 2;
    step();
    idle();
    rd0_fp = 1; rd0_num = 7; rd1_fp = 0; rd1_num = 7;
    #1; chk(0, "R10"); chk(1, "R10");

    finish_run();
  end
endmodule